// File: doc/BRIEF.md
# Register Renamer with Speculative and Committed Map Tables

This block sits in the rename stage of an out-of-order core. Each cycle it can take one micro-op. The micro-op names up to two source registers and an optional destination register, all drawn from a set of eight architectural registers. The block translates the sources into 7-bit tags that index a 128-entry physical register file. For a destination, it hands out a fresh physical tag from a pool of unused registers. It also returns the tag the destination held before, so the reorder logic can keep it with the micro-op.

Two map tables are kept. The speculative table is read and written at rename. The committed table is written only when the retire interface reports that a micro-op has committed. Commit never moves a register value. It rewrites one pointer in the committed table and returns the tag that pointer replaced to the pool.

On a flush, the whole committed table is copied into the speculative table in a single cycle. The pool is then rebuilt as every physical register that the committed table does not reference.

Top module: `reg_renamer`

## Requirements
- R1: After reset, each architectural register i maps to physical tag i in both tables, physical tags 8 to 127 are free, and `ren_ready` is 1.
- R2: `ren_src0_phys` and `ren_src1_phys` show, in the same cycle, the speculative mapping of `ren_src0_arch` and `ren_src1_arch` as it stood before this cycle's rename, so a source equal to the micro-op's own destination sees the previous mapping.
- R3: When `ren_valid`, `ren_ready` and `ren_has_dst` are all 1, `ren_dst_phys` is the lowest-numbered free physical tag and `ren_prev_phys` is the current speculative mapping of `ren_dst_arch`. From the next cycle, the speculative table maps `ren_dst_arch` to that tag and the tag is no longer free.
- R4: A micro-op accepted with `ren_has_dst` = 0 takes no tag from the pool and leaves the speculative table unchanged.
- R5: `ren_ready` is 0 whenever no physical tag is free. A micro-op offered while `ren_ready` is 0 changes no state.
- R6: When `ret_valid` is 1, the committed table maps `ret_dst_arch` to `ret_dst_phys` from the next cycle, and the tag it held before becomes free from the next cycle.
- R7: When `flush` is 1, in the next cycle the speculative table equals the committed table, including any retire in the same cycle. The pool then holds exactly the 120 tags that the committed table does not reference.
- R8: In a cycle with `flush` = 1, `ren_ready` is 0 and any offered micro-op is ignored.
- R9: A cycle with `ren_valid` = 0 leaves the speculative table and the pool unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ren_valid | input | 1 | A micro-op is offered for rename |
| ren_has_dst | input | 1 | The offered micro-op writes a destination |
| ren_dst_arch | input | 3 | Destination architectural register |
| ren_src0_arch | input | 3 | First source architectural register |
| ren_src1_arch | input | 3 | Second source architectural register |
| ren_ready | output | 1 | Rename can accept the offered micro-op this cycle |
| ren_src0_phys | output | 7 | Physical tag of first source |
| ren_src1_phys | output | 7 | Physical tag of second source |
| ren_dst_phys | output | 7 | Tag allocated to the destination |
| ren_prev_phys | output | 7 | Tag the destination mapped to before this rename |
| ret_valid | input | 1 | A micro-op with a destination commits |
| ret_dst_arch | input | 3 | Committed destination architectural register |
| ret_dst_phys | input | 7 | Tag the committed micro-op was given at rename |
| flush | input | 1 | Discard speculative state and recover from the committed table |

## Verification
Random traffic mixes renames with and without destinations, in-order commits taken from a queue of renamed micro-ops, idle cycles and rare flushes. Every lookup is compared with a model of both tables and the pool, which tests the lowest-free allocation order and the reuse of freed tags. Directed sequences first exhaust the pool to show that stall holds all state. They then free a single tag to show it is reused at once, and put a retire and a flush in the same cycle to show that recovery sees the fresh commit. The committed table is never visible directly; each flush exposes it through the source lookups that follow, which tells a missed commit apart from a missed copy.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int NUM_ARCH = 8;
  localparam int NUM_PHYS = 128;
  localparam int ARCH_W   = $clog2(NUM_ARCH);
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int POOL_INIT = NUM_PHYS - NUM_ARCH;

  typedef logic [ARCH_W-1:0] arch_t;
  typedef logic [PHYS_W-1:0] phys_t;
  typedef phys_t [NUM_ARCH-1:0] map_t;
  typedef logic [NUM_PHYS-1:0] pool_t;
endpackage

// File: rtl/rr_reset_sync.sv
module rr_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/rr_alias_table.sv
module rr_alias_table
  import rr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  arch_t wr_idx,
  input  phys_t wr_tag,
  input  logic  load_en,
  input  map_t  load_map,
  output map_t  map_o
);
  map_t map_q;
  map_t map_nxt;
  logic upd_en;

  // next-state: a bulk load wins over a single write
  always_comb begin
    map_nxt = map_q;
    if (load_en) begin
      map_nxt = load_map;
    end else if (wr_en) begin
      map_nxt[wr_idx] = wr_tag;
    end
  end

  assign upd_en = load_en | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        map_q[i] <= phys_t'(i);
      end
    end else if (upd_en) begin
      map_q <= map_nxt;
    end
  end

  assign map_o = map_q;

  AST_LOAD_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> map_q == $past(load_map)); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_en) |=> map_q[$past(wr_idx)] == $past(wr_tag)); // R3
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list
  import rr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_en,
  input  logic  rel_en,
  input  phys_t rel_tag,
  input  logic  rebuild_en,
  input  pool_t rebuild_mask,
  output logic  avail,
  output phys_t alloc_tag
);
  pool_t free_q;
  pool_t free_nxt;
  logic  upd_en;

  // lowest-numbered free tag: scan from the top so the lowest index wins
  always_comb begin
    alloc_tag = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        alloc_tag = phys_t'(i);
      end
    end
  end

  assign avail = |free_q;

  always_comb begin
    free_nxt = free_q;
    if (rebuild_en) begin
      free_nxt = rebuild_mask;
    end else begin
      if (alloc_en) begin
        free_nxt[alloc_tag] = 1'b0;
      end
      if (rel_en) begin
        free_nxt[rel_tag] = 1'b1;
      end
    end
  end

  assign upd_en = rebuild_en | alloc_en | rel_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        free_q[i] <= (i >= NUM_ARCH);
      end
    end else if (upd_en) begin
      free_q <= free_nxt;
    end
  end

  AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !rebuild_en) |-> !free_q[rel_tag]); // R6
  AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !rebuild_en) |=> !free_q[$past(alloc_tag)]); // R3
  AST_REBUILD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rebuild_en |=> $countones(free_q) == POOL_INIT); // R7
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic              ren_has_dst,
  input  logic [ARCH_W-1:0] ren_dst_arch,
  input  logic [ARCH_W-1:0] ren_src0_arch,
  input  logic [ARCH_W-1:0] ren_src1_arch,
  output logic              ren_ready,
  output logic [PHYS_W-1:0] ren_src0_phys,
  output logic [PHYS_W-1:0] ren_src1_phys,
  output logic [PHYS_W-1:0] ren_dst_phys,
  output logic [PHYS_W-1:0] ren_prev_phys,
  input  logic              ret_valid,
  input  logic [ARCH_W-1:0] ret_dst_arch,
  input  logic [PHYS_W-1:0] ret_dst_phys,
  input  logic              flush
);
  logic  rst_n_s;
  map_t  spec_map;
  map_t  cmt_map;
  map_t  cmt_map_nxt;
  pool_t pool_mask;
  logic  pool_avail;
  phys_t pool_tag;
  logic  do_alloc;
  phys_t cmt_old_tag;

  rr_reset_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign ren_ready     = pool_avail & ~flush;
  assign do_alloc      = ren_valid & ren_ready & ren_has_dst;
  assign ren_src0_phys = spec_map[ren_src0_arch];
  assign ren_src1_phys = spec_map[ren_src1_arch];
  assign ren_prev_phys = spec_map[ren_dst_arch];
  assign ren_dst_phys  = pool_tag;
  assign cmt_old_tag   = cmt_map[ret_dst_arch];

  // committed view including this cycle's retire, used by recovery
  always_comb begin
    cmt_map_nxt = cmt_map;
    if (ret_valid) begin
      cmt_map_nxt[ret_dst_arch] = ret_dst_phys;
    end
  end

  always_comb begin
    pool_mask = '1;
    for (int a = 0; a < NUM_ARCH; a++) begin
      pool_mask[cmt_map_nxt[a]] = 1'b0;
    end
  end

  rr_alias_table u_spec (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (do_alloc),
    .wr_idx   (ren_dst_arch),
    .wr_tag   (pool_tag),
    .load_en  (flush),
    .load_map (cmt_map_nxt),
    .map_o    (spec_map)
  );

  rr_alias_table u_cmt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (ret_valid),
    .wr_idx   (ret_dst_arch),
    .wr_tag   (ret_dst_phys),
    .load_en  (1'b0),
    .load_map (cmt_map),
    .map_o    (cmt_map)
  );

  rr_free_list u_pool (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .alloc_en     (do_alloc),
    .rel_en       (ret_valid),
    .rel_tag      (cmt_old_tag),
    .rebuild_en   (flush),
    .rebuild_mask (pool_mask),
    .avail        (pool_avail),
    .alloc_tag    (pool_tag)
  );

  AST_FLUSH_MATCH: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> spec_map == cmt_map); // R7
  AST_CMT_POINTER: assert property (@(posedge clk) disable iff (!rst_n_s)
    ret_valid |=> cmt_map[$past(ret_dst_arch)] == $past(ret_dst_phys)); // R6
  AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!flush && !(ren_valid && ren_ready && ren_has_dst)) |=> $stable(spec_map)); // R5
  AST_SPEC_RENAMED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ren_valid && ren_ready && ren_has_dst) |=> spec_map[$past(ren_dst_arch)] == $past(ren_dst_phys)); // R3
endmodule

// File: tb/reg_renamer_tb_top.sv
module reg_renamer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NP = 128;
  localparam int QD = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_has_dst, ret_valid, flush;
  logic [2:0] ren_dst_arch, ren_src0_arch, ren_src1_arch, ret_dst_arch;
  logic [6:0] ret_dst_phys;
  logic       ren_ready;
  logic [6:0] ren_src0_phys, ren_src1_phys, ren_dst_phys, ren_prev_phys;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int spec_m [NA];
  int cmt_m  [NA];
  bit pool_m [NP];
  int q_arch [QD];
  int q_phys [QD];
  int q_head = 0;
  int q_cnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_renamer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_valid     (ren_valid),
    .ren_has_dst   (ren_has_dst),
    .ren_dst_arch  (ren_dst_arch),
    .ren_src0_arch (ren_src0_arch),
    .ren_src1_arch (ren_src1_arch),
    .ren_ready     (ren_ready),
    .ren_src0_phys (ren_src0_phys),
    .ren_src1_phys (ren_src1_phys),
    .ren_dst_phys  (ren_dst_phys),
    .ren_prev_phys (ren_prev_phys),
    .ret_valid     (ret_valid),
    .ret_dst_arch  (ret_dst_arch),
    .ret_dst_phys  (ret_dst_phys),
    .flush         (flush)
  );

  function automatic int pool_count();
    int c = 0;
    for (int i = 0; i < NP; i++) c += pool_m[i];
    return c;
  endfunction

  function automatic int pool_lowest();
    for (int i = 0; i < NP; i++) if (pool_m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < NA; a++) begin
      spec_m[a] = a;
      cmt_m[a]  = a;
    end
    for (int i = 0; i < NP; i++) pool_m[i] = (i >= NA);
    q_head = 0;
    q_cnt  = 0;
  endtask

  // one cycle: drive, check lookups, then update model at the edge
  task automatic step(input bit v, input bit hd, input int d, input int s0,
                      input int s1, input bit rv, input bit fl, input string src_tag);
    bit do_ret;
    int r_arch, r_phys, low, old;
    bit exp_rdy;
    @(negedge clk);
    do_ret = rv && (q_cnt > 0);
    r_arch = do_ret ? q_arch[q_head] : 0;
    r_phys = do_ret ? q_phys[q_head] : 0;
    ren_valid     = v;
    ren_has_dst   = hd;
    ren_dst_arch  = 3'(d);
    ren_src0_arch = 3'(s0);
    ren_src1_arch = 3'(s1);
    ret_valid     = do_ret;
    ret_dst_arch  = 3'(r_arch);
    ret_dst_phys  = 7'(r_phys);
    flush         = fl;
    #1;
    exp_rdy = (pool_count() > 0) && !fl;
    chk(fl ? "R8 ready in flush" : "R5 ready", int'(ren_ready), int'(exp_rdy));
    chk({src_tag, " src0"}, int'(ren_src0_phys), spec_m[s0]);
    chk({src_tag, " src1"}, int'(ren_src1_phys), spec_m[s1]);
    low = pool_lowest();
    if (exp_rdy && v && hd) begin
      chk("R3 dst tag", int'(ren_dst_phys), low);
      chk("R3 prev tag", int'(ren_prev_phys), spec_m[d]);
    end
    @(posedge clk);
    if (v && exp_rdy && hd) begin
      pool_m[low] = 1'b0;
      spec_m[d] = low;
      q_arch[(q_head + q_cnt) % QD] = d;
      q_phys[(q_head + q_cnt) % QD] = low;
      q_cnt++;
    end
    if (do_ret) begin
      old = cmt_m[r_arch];
      cmt_m[r_arch] = r_phys;
      pool_m[old] = 1'b1;
      q_head = (q_head + 1) % QD;
      q_cnt--;
    end
    if (fl) begin
      for (int i = 0; i < NP; i++) pool_m[i] = 1'b1;
      for (int a = 0; a < NA; a++) begin
        spec_m[a] = cmt_m[a];
        pool_m[cmt_m[a]] = 1'b0;
      end
      q_head = 0;
      q_cnt  = 0;
    end
  endtask

  task automatic idle_inputs();
    ren_valid = 0; ren_has_dst = 0; ren_dst_arch = 0; ren_src0_arch = 0;
    ren_src1_arch = 0; ret_valid = 0; ret_dst_arch = 0; ret_dst_phys = 0; flush = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: identity mapping after reset
    for (int a = 0; a < NA; a++) begin
      @(negedge clk);
      ren_src0_arch = 3'(a);
      ren_src1_arch = 3'(NA - 1 - a);
      #1;
      chk("R1 src0 identity", int'(ren_src0_phys), a);
      chk("R1 src1 identity", int'(ren_src1_phys), NA - 1 - a);
      chk("R1 ready", int'(ren_ready), 1);
    end

    // R2: source equals own destination sees previous mapping
    step(1, 1, 3, 3, 3, 0, 0, "R2");
    step(1, 1, 3, 3, 2, 0, 0, "R2");
    // R4: accepted micro-op without destination changes nothing
    step(1, 0, 5, 5, 3, 0, 0, "R4");
    step(0, 0, 0, 5, 3, 0, 0, "R4");
    // R9: idle cycle leaves state
    step(0, 1, 2, 2, 3, 0, 0, "R9");
    step(1, 1, 2, 2, 3, 0, 0, "R9");
    // R6 then R7: commit two, flush, observe committed table through lookups
    step(0, 0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 3, 2, 1, 0, "R6");
    step(0, 0, 0, 3, 2, 0, 1, "R7");
    step(0, 0, 0, 3, 2, 0, 0, "R7");
    chk("R7 pool size", pool_count(), NP - NA);

    // R5: exhaust the pool, stall holds state, a freed tag is reused
    for (int i = 0; i < NP - NA; i++) step(1, 1, i % NA, i % NA, (i + 1) % NA, 0, 0, "R5");
    step(1, 1, 1, 1, 2, 0, 0, "R5");
    step(1, 1, 4, 4, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 4, 1, 0, "R6");
    step(1, 1, 6, 6, 0, 0, 0, "R6");
    // R7 and R8: retire and flush in the same cycle with a rename offered
    step(1, 1, 7, 7, 1, 1, 1, "R8");
    step(0, 0, 0, 1, 2, 0, 0, "R7");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit v, hd, rv, fl;
      v  = ($urandom % 10) < 7;
      hd = ($urandom % 10) < 8;
      rv = ($urandom % 10) < 4;
      fl = ($urandom % 100) < 2;
      step(v, hd, $urandom % NA, $urandom % NA, $urandom % NA, rv, fl, "R2");
    end

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule